// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block generates the bus-control timing of an 8051-style core that reaches external program and data memory over a multiplexed address/data bus. Each machine cycle lasts twelve oscillator clocks and is split into two halves of six clocks. The address-latch strobe pulses at the start of each half. The program-store strobe and the data read and write strobes fall in the later part of a half, after the low address byte has been latched and released. The block also selects whether each code fetch goes to on-chip flash or to external memory. That choice depends on the external-access pin and on a program-counter boundary set by the flash size parameter.

The core presents one request per machine cycle: a code fetch, or an external data read or write with an 8-bit or 16-bit address. The request is sampled at the last clock of the previous machine cycle, which the block flags on `cycSample`. A raw reset pin is synchronised and qualified. The core reset is raised only after the pin has been held high for two whole machine cycles.

Top module: `ebus_strobe_seq`

## Requirements
- R1: In a code-fetch cycle, `ale` is high in machine-cycle clocks 0-1 and 6-7, giving two pulses per machine cycle. This holds for both internal and external fetches.
- R2: In an external data cycle, only the first `ale` pulse (clocks 0-1) occurs. The second pulse is suppressed.
- R3: In an external code fetch, `psenN` is low in clocks 3-4 and 9-10, giving two pulses per machine cycle.
- R4: In an external data cycle, `psenN` stays high for the whole machine cycle.
- R5: In an internal code fetch, `psenN` stays high. Both address-drive enables stay low, and both address outputs read 0.
- R6: A fetch is external when the external-access pin is low, or when the program counter exceeds FLASH_KB*1024-1. With FLASH_KB=64, a fetch with the pin high is always internal.
- R7: In a data read cycle, `rdN` is low in clocks 3 to 10 (eight clocks). In a data write cycle, `wrN` is low in the same clocks. The two are never low together.
- R8: While `addrHiOe` is high, `addrHi` carries one of three values. In a 16-bit data cycle it is `dataAddr[15:8]`. In an 8-bit data cycle it is `p2Reg`. In an external fetch it is `pc[15:8]` in the first half and (pc+1)[15:8] in the second half. The value is stable within a half.
- R9: `addrLoOe` is high only while `ale` is high. It is never high while a program-store, read or write strobe is active. The low byte is `dataAddr[7:0]` in a data cycle (first half only), and pc[7:0] then (pc+1)[7:0] in an external fetch.
- R10: `coreRst` rises on the 26th rising edge after `rstPin` goes high and stays high (two-flop synchroniser plus 24 qualifying clocks). A shorter high pulse does not reset. `coreRst` falls on the 3rd rising edge after `rstPin` goes low.
- R11: While `coreRst` is high, `ale`, `addrLoOe`, `addrHiOe` and `cycSample` are low, and `psenN`, `rdN` and `wrN` are high. The first machine cycle starts at clock 0 on the edge where `coreRst` falls, using the request present at that edge.
- R12: `cycSample` is high in clock 11 of every machine cycle. The request inputs present at that clock's closing edge define the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstPin | input | 1 | Raw reset pin, active high, asynchronous |
| eaPin | input | 1 | External-access pin; low forces external code fetch |
| reqData | input | 1 | Next cycle is an external data access (0 = code fetch) |
| reqWrite | input | 1 | Data access is a write (0 = read) |
| reqWide | input | 1 | Data access uses a 16-bit address (0 = 8-bit) |
| pc | input | 16 | Program counter for the next fetch |
| dataAddr | input | 16 | Data address for the next data access |
| p2Reg | input | 8 | Port-2 register contents, driven high for 8-bit data accesses |
| coreRst | output | 1 | Qualified core reset |
| cycSample | output | 1 | Last clock of the machine cycle; request sampled at its closing edge |
| ale | output | 1 | Address-latch strobe, active high |
| psenN | output | 1 | Program-store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| addrLo | output | 8 | Low address byte (0 when not driven) |
| addrLoOe | output | 1 | Drive enable for the low address byte |
| addrHi | output | 8 | High address byte (0 when not driven) |
| addrHiOe | output | 1 | Drive enable for the high address byte |

## Verification
The assertions assume that the request inputs change only while `cycSample` is low, or just after its closing edge. They also assume the raw reset pin has been low for a few clocks before it is first raised, so the qualifier starts from zero. The stimulus changes every input at a falling clock edge during clock 11, once per machine cycle, and starts with the reset pin low. Sampled values are therefore captured cleanly at the boundary. The strobe-overlap and hold-stability properties then depend only on the sequencer's own phase.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  // Strobe bundle that the control issues to the address datapath.
  typedef struct packed {
    logic capture;    // latch the request this edge
    logic upperHalf;  // second half of the machine cycle
    logic isData;     // current cycle is an external data access
    logic isWide;     // data access uses a 16-bit address
    logic aleOn;
    logic psenOn;
    logic rdOn;
    logic wrOn;
    logic loOe;
    logic hiOe;
  } busStrobe_t;
endpackage

// File: rtl/ebus_rst_qual.sv
module ebus_rst_qual #(
  parameter int unsigned QUAL_CLKS = 24
) (
  input  logic clk,
  input  logic rstPin,
  output logic coreRst
);
  localparam int unsigned CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL_CLKS);
  localparam logic [CW-1:0] CNT_FIRE = CW'(QUAL_CLKS - 1);

  logic syncA, syncB;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    syncA <= rstPin;
    syncB <= syncA;
  end

  always_ff @(posedge clk) begin
    if (!syncB) begin
      holdCnt <= '0;
      coreRst <= 1'b0;
    end else begin
      if (holdCnt != CNT_MAX) holdCnt <= holdCnt + 1'b1;
      if (holdCnt >= CNT_FIRE) coreRst <= 1'b1;
    end
  end
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter int unsigned MC_CLKS = 12
) (
  input  logic       clk,
  input  logic       coreRst,
  input  logic       reqData,
  input  logic       reqWrite,
  input  logic       reqWide,
  input  logic       extFetch,
  output busStrobe_t st,
  output logic       cycSample
);
  localparam int unsigned PW     = $clog2(MC_CLKS);
  localparam int unsigned HALF   = MC_CLKS / 2;
  localparam int unsigned PULSE  = HALF / 3;
  localparam int unsigned STB_LO = HALF / 2;
  localparam logic [PW-1:0] LAST    = PW'(MC_CLKS - 1);
  localparam logic [PW-1:0] HALF_P  = PW'(HALF);
  localparam logic [PW-1:0] PULSE_P = PW'(PULSE);
  localparam logic [PW-1:0] STB_P   = PW'(STB_LO);
  localparam logic [PW-1:0] STB_END = PW'(STB_LO + PULSE);
  localparam logic [PW-1:0] RW_LAST = PW'(MC_CLKS - 2);

  logic [PW-1:0] phase, halfPos;
  logic isDataR, isWrR, isWideR;
  logic upper, run, fetchExt, rwWin, capture;

  assign capture = coreRst || (phase == LAST);

  always_ff @(posedge clk) begin
    if (coreRst || phase == LAST) phase <= '0;
    else                          phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      isDataR <= reqData;
      isWrR   <= reqWrite;
      isWideR <= reqWide;
    end
  end

  always_comb begin
    run      = !coreRst;
    upper    = phase >= HALF_P;
    halfPos  = upper ? phase - HALF_P : phase;
    fetchExt = !isDataR && extFetch;
    rwWin    = (phase >= STB_P) && (phase <= RW_LAST);

    st.capture   = capture;
    st.upperHalf = upper;
    st.isData    = isDataR;
    st.isWide    = isWideR;
    st.aleOn     = run && (halfPos < PULSE_P) && !(isDataR && upper);
    st.psenOn    = run && fetchExt && (halfPos >= STB_P) && (halfPos < STB_END);
    st.rdOn      = run && isDataR && !isWrR && rwWin;
    st.wrOn      = run && isDataR && isWrR && rwWin;
    st.loOe      = run && (halfPos < PULSE_P) && (isDataR ? !upper : extFetch);
    st.hiOe      = run && (isDataR || extFetch);
  end

  assign cycSample = run && (phase == LAST);

  p_ale_pair_r1: assert property (@(posedge clk) disable iff (coreRst)
    $rose(st.aleOn) |=> st.aleOn);
  p_psen_pair_r3: assert property (@(posedge clk) disable iff (coreRst)
    $rose(st.psenOn) |=> st.psenOn);
  p_rdwr_excl_r7: assert property (@(posedge clk) disable iff (coreRst)
    !(st.rdOn && st.wrOn));
  p_lo_release_r9: assert property (@(posedge clk) disable iff (coreRst)
    st.loOe |-> !(st.psenOn || st.rdOn || st.wrOn));
endmodule

// File: rtl/ebus_dpath.sv
module ebus_dpath
  import ebus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned FLASH_KB = 32
) (
  input  logic                  clk,
  input  logic                  coreRst,
  input  busStrobe_t            st,
  input  logic                  eaPin,
  input  logic [ADDR_W-1:0]     pc,
  input  logic [ADDR_W-1:0]     dataAddr,
  input  logic [ADDR_W-9:0]     p2Reg,
  output logic                  extFetch,
  output logic [7:0]            addrLo,
  output logic [ADDR_W-9:0]     addrHi
);
  localparam int unsigned LO_W  = 8;
  localparam int unsigned HI_W  = ADDR_W - LO_W;
  localparam longint unsigned FLASH_BYTES = longint'(FLASH_KB) * 1024;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(FLASH_BYTES - 1);

  logic [ADDR_W-1:0] pcLat, daLat, pcInc, pcSel;
  logic [HI_W-1:0]   p2Lat;
  logic              eaLat, beyond;
  logic              unusedStrobes;

  always_ff @(posedge clk) begin
    if (st.capture) begin
      pcLat <= pc;
      daLat <= dataAddr;
      p2Lat <= p2Reg;
      eaLat <= eaPin;
    end
  end

  assign pcInc = pcLat + 1'b1;
  assign pcSel = st.upperHalf ? pcInc : pcLat;

  generate
    if (FLASH_BYTES >= (longint'(1) << ADDR_W)) begin : g_full_map
      assign beyond = 1'b0;
    end else begin : g_part_map
      assign beyond = {1'b0, pcLat} > LIMIT;
    end
  endgenerate

  assign extFetch = !eaLat || beyond;

  always_comb begin
    if (!st.loOe)        addrLo = '0;
    else if (st.isData)  addrLo = daLat[LO_W-1:0];
    else                 addrLo = pcSel[LO_W-1:0];

    if (!st.hiOe)        addrHi = '0;
    else if (!st.isData) addrHi = pcSel[ADDR_W-1:LO_W];
    else if (st.isWide)  addrHi = daLat[ADDR_W-1:LO_W];
    else                 addrHi = p2Lat;
  end

  assign unusedStrobes = ^{st.aleOn, st.psenOn, st.rdOn, st.wrOn};

  p_hi_stable_r8: assert property (@(posedge clk) disable iff (coreRst)
    (st.hiOe && $past(st.hiOe) && !$past(st.capture) &&
     (st.upperHalf == $past(st.upperHalf))) |-> $stable(addrHi));
endmodule

// File: rtl/ebus_strobe_seq.sv
module ebus_strobe_seq
  import ebus_pkg::*;
#(
  parameter int unsigned FLASH_KB = 32,
  parameter int unsigned MC_CLKS  = 12,
  parameter int unsigned ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rstPin,
  input  logic              eaPin,
  input  logic              reqData,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [ADDR_W-9:0] p2Reg,
  output logic              coreRst,
  output logic              cycSample,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [7:0]        addrLo,
  output logic              addrLoOe,
  output logic [ADDR_W-9:0] addrHi,
  output logic              addrHiOe
);
  localparam int unsigned QUAL_CLKS = 2 * MC_CLKS;

  busStrobe_t st;
  logic       extFetch;

  ebus_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk(clk), .rstPin(rstPin), .coreRst(coreRst));

  ebus_ctrl #(.MC_CLKS(MC_CLKS)) u_ctrl (
    .clk(clk), .coreRst(coreRst), .reqData(reqData), .reqWrite(reqWrite),
    .reqWide(reqWide), .extFetch(extFetch), .st(st), .cycSample(cycSample));

  ebus_dpath #(.ADDR_W(ADDR_W), .FLASH_KB(FLASH_KB)) u_dpath (
    .clk(clk), .coreRst(coreRst), .st(st), .eaPin(eaPin), .pc(pc),
    .dataAddr(dataAddr), .p2Reg(p2Reg), .extFetch(extFetch),
    .addrLo(addrLo), .addrHi(addrHi));

  assign ale      = st.aleOn;
  assign psenN    = !st.psenOn;
  assign rdN      = !st.rdOn;
  assign wrN      = !st.wrOn;
  assign addrLoOe = st.loOe;
  assign addrHiOe = st.hiOe;
endmodule

// File: tb/ebus_strobe_seq_tb.sv
`timescale 1ns/1ps
module ebus_strobe_seq_tb_top;
  typedef struct packed {
    logic isData, isWr, isWide, ea;
    logic [15:0] pc, da;
    logic [7:0]  p2;
    logic [1:0]  eAle, ePsen;
    logic [3:0]  eRd, eWr;
    logic        eDrv;
    logic [3:0]  eLoOe;
    logic [7:0]  hi0, lo0, hi6, lo6;
  } vec_t;

  localparam int NV = 12;
  // FLASH_KB=32: fetch boundary 7FFF
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,16'h0100,16'h0000,8'h00,2'd2,2'd0,4'd0,4'd0,1'b0,4'd0,8'h00,8'h00,8'h00,8'h00},
    '{1'b0,1'b0,1'b0,1'b0,16'h0100,16'h0000,8'h00,2'd2,2'd2,4'd0,4'd0,1'b1,4'd4,8'h01,8'h00,8'h01,8'h01},
    '{1'b0,1'b0,1'b0,1'b1,16'h7FFF,16'h0000,8'h00,2'd2,2'd0,4'd0,4'd0,1'b0,4'd0,8'h00,8'h00,8'h00,8'h00},
    '{1'b0,1'b0,1'b0,1'b1,16'h8000,16'h0000,8'h00,2'd2,2'd2,4'd0,4'd0,1'b1,4'd4,8'h80,8'h00,8'h80,8'h01},
    '{1'b0,1'b0,1'b0,1'b0,16'h00FF,16'h0000,8'h00,2'd2,2'd2,4'd0,4'd0,1'b1,4'd4,8'h00,8'hFF,8'h01,8'h00},
    '{1'b1,1'b0,1'b1,1'b1,16'h0000,16'h1234,8'hAA,2'd1,2'd0,4'd8,4'd0,1'b1,4'd2,8'h12,8'h34,8'h12,8'h00},
    '{1'b1,1'b1,1'b0,1'b1,16'h0000,16'h0056,8'hC3,2'd1,2'd0,4'd0,4'd8,1'b1,4'd2,8'hC3,8'h56,8'hC3,8'h00},
    '{1'b1,1'b0,1'b0,1'b0,16'h0000,16'hABCD,8'h5A,2'd1,2'd0,4'd8,4'd0,1'b1,4'd2,8'h5A,8'hCD,8'h5A,8'h00},
    '{1'b1,1'b1,1'b1,1'b1,16'h0000,16'hFEDC,8'h00,2'd1,2'd0,4'd0,4'd8,1'b1,4'd2,8'hFE,8'hDC,8'hFE,8'h00},
    '{1'b0,1'b0,1'b0,1'b1,16'hFFFF,16'h0000,8'h00,2'd2,2'd2,4'd0,4'd0,1'b1,4'd4,8'hFF,8'hFF,8'h00,8'h00},
    '{1'b0,1'b0,1'b0,1'b0,16'h3FFF,16'h0000,8'h00,2'd2,2'd2,4'd0,4'd0,1'b1,4'd4,8'h3F,8'hFF,8'h40,8'h00},
    '{1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0000,8'h00,2'd2,2'd0,4'd0,4'd0,1'b0,4'd0,8'h00,8'h00,8'h00,8'h00}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstPin, eaPin, reqData, reqWrite, reqWide;
  logic [15:0] pc, dataAddr;
  logic [7:0]  p2Reg;
  logic coreRst, cycSample, ale, psenN, rdN, wrN, addrLoOe, addrHiOe;
  logic [7:0] addrLo, addrHi;
  logic coreRst64, cycSample64, ale64, psenN64, rdN64, wrN64, loOe64, hiOe64;
  logic [7:0] addrLo64, addrHi64;

  int total = 0;
  int bad = 0;
  bit done = 0;

  ebus_strobe_seq #(.FLASH_KB(32)) dut_i (
    .clk(clk), .rstPin(rstPin), .eaPin(eaPin), .reqData(reqData),
    .reqWrite(reqWrite), .reqWide(reqWide), .pc(pc), .dataAddr(dataAddr),
    .p2Reg(p2Reg), .coreRst(coreRst), .cycSample(cycSample), .ale(ale),
    .psenN(psenN), .rdN(rdN), .wrN(wrN), .addrLo(addrLo), .addrLoOe(addrLoOe),
    .addrHi(addrHi), .addrHiOe(addrHiOe));

  ebus_strobe_seq #(.FLASH_KB(64)) dut64_i (
    .clk(clk), .rstPin(rstPin), .eaPin(eaPin), .reqData(reqData),
    .reqWrite(reqWrite), .reqWide(reqWide), .pc(pc), .dataAddr(dataAddr),
    .p2Reg(p2Reg), .coreRst(coreRst64), .cycSample(cycSample64), .ale(ale64),
    .psenN(psenN64), .rdN(rdN64), .wrN(wrN64), .addrLo(addrLo64), .addrLoOe(loOe64),
    .addrHi(addrHi64), .addrHiOe(hiOe64));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input vec_t v);
    reqData = v.isData; reqWrite = v.isWr; reqWide = v.isWide;
    eaPin = v.ea; pc = v.pc; dataAddr = v.da; p2Reg = v.p2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R12 watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    rstPin = 1'b0;
    apply(VEC[0]);
    repeat (4) @(negedge clk);

    // R10: a 20-clock pulse is too short
    seen = 1'b0;
    rstPin = 1'b1;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (coreRst) seen = 1'b1; end
    rstPin = 1'b0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); if (coreRst) seen = 1'b1; end
    chk(!seen, "R10 short pulse", seen, 0);

    // R10: qualification edge count
    rstPin = 1'b1;
    repeat (25) @(posedge clk);
    @(negedge clk);
    chk(coreRst == 1'b0, "R10 after 25 edges", coreRst, 0);
    @(negedge clk);
    chk(coreRst == 1'b1, "R10 after 26 edges", coreRst, 1);

    // R11: idle outputs under reset
    repeat (3) @(negedge clk);
    chk({ale, addrLoOe, addrHiOe, cycSample} == 4'b0000, "R11 reset actives",
        {ale, addrLoOe, addrHiOe, cycSample}, 0);
    chk({psenN, rdN, wrN} == 3'b111, "R11 reset strobes", {psenN, rdN, wrN}, 7);

    rstPin = 1'b0;
    @(negedge clk);
    chk(coreRst == 1'b1, "R10 release edge 1", coreRst, 1);
    @(negedge clk);
    chk(coreRst == 1'b1, "R10 release edge 2", coreRst, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int aleN, psN, ps64N, rdC, wrC, loC;
      bit aleP, psP, ps64P;
      v = VEC[i];
      aleN = 0; psN = 0; ps64N = 0; rdC = 0; wrC = 0; loC = 0;
      aleP = 1'b0; psP = 1'b1; ps64P = 1'b1;
      for (int j = 0; j < 12; j++) begin
        @(negedge clk);
        if (i == 0 && j == 0) chk(coreRst == 1'b0, "R10 R11 release", coreRst, 0);
        if (ale && !aleP) aleN++;
        if (!psenN && psP) psN++;
        if (!psenN64 && ps64P) ps64N++;
        aleP = ale; psP = psenN; ps64P = psenN64;
        if (!rdN) rdC++;
        if (!wrN) wrC++;
        if (addrLoOe) loC++;
        if (addrLoOe && (!psenN || !rdN || !wrN))
          chk(1'b0, "R9 lo overlap", i, j);
        if (addrLoOe && !ale) chk(1'b0, "R9 lo outside ale", i, j);
        if (j == 0) begin
          if (v.eDrv) begin
            chk(addrHiOe && addrHi == v.hi0, "R8 hi first half", addrHi, v.hi0);
            chk(addrLoOe && addrLo == v.lo0, "R9 lo first half", addrLo, v.lo0);
          end else begin
            chk({addrHiOe, addrLoOe, addrHi, addrLo} == 18'd0, "R5 R6 no drive",
                {addrHiOe, addrLoOe}, 0);
          end
        end
        if (j == 6 && v.eDrv) begin
          chk(addrHiOe && addrHi == v.hi6, "R8 hi second half", addrHi, v.hi6);
          if (!v.isData) chk(addrLoOe && addrLo == v.lo6, "R9 lo second half", addrLo, v.lo6);
          else           chk(!addrLoOe, "R2 R9 no second lo", addrLoOe, 0);
        end
        chk(cycSample == (j == 11), "R12 sample flag", cycSample, (j == 11));
        if (j == 11) apply((i + 1 < NV) ? VEC[i + 1] : VEC[0]);
      end
      chk(aleN == v.eAle, v.isData ? "R2 ale skip" : "R1 ale pair", aleN, v.eAle);
      chk(psN == v.ePsen, v.isData ? "R4 psen skip" : "R3 R5 R6 psen", psN, v.ePsen);
      chk(rdC == v.eRd, "R7 rd span", rdC, v.eRd);
      chk(wrC == v.eWr, "R7 wr span", wrC, v.eWr);
      chk(loC == v.eLoOe, "R9 lo drive span", loC, v.eLoOe);
      chk(ps64N == ((!v.isData && !v.ea) ? 2 : 0), "R6 full map psen", ps64N,
          (!v.isData && !v.ea) ? 2 : 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule